// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall time as a single binary count advanced by a 32.768 kHz tick strobe. The count is 47 bits wide: the high 32 bits are whole seconds and the low 15 bits are the fraction of a second, so the seconds word steps once every 32768 ticks. Software loads and reads the seconds word, the fraction, a 32-bit seconds alarm and a small control register through simple write strobes and read ports, and it clears status flags by writing ones to a clear port.

A three-state controller decides when the count may advance. `ST_SEED` is entered from reset and from any state whenever the security inputs report an invalid or failure condition; it waits for an accepted seconds write made while both of those inputs are low, then moves to `ST_HOLD`. `ST_HOLD` moves to `ST_RUN` once the enable bit is set and the overflow flag is clear. `ST_RUN` falls back to `ST_HOLD` when the enable bit drops or the overflow flag sets. Counting is also gated in the same cycle by every stop cause, so no tick slips through during a transition.

The alarm flag sets on the cycle after the seconds word becomes equal to the alarm value, unless the alarm value is all ones, which means no alarm. The flag drives an interrupt output through an enable bit. Lock bits keep the time from being rewritten while the counter is disabled.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the seconds word and fraction read zero, the alarm reads all ones, the control register reads zero, both status flags read zero and the count does not advance.
- R2: In `ST_RUN`, each cycle with the tick strobe high adds one to the 47-bit count; the seconds word steps when the fraction passes 32767 and the fraction returns to zero.
- R3: After reset, or after the invalid or failure input has been high, the count does not advance, even with every stop cause removed, until a seconds write is accepted while both inputs are low.
- R4: The count holds its value while the enable bit (control bit 0) is clear, the overflow flag is set, the invalid input is high or the failure input is high.
- R5: An accepted seconds write loads the seconds word and clears the fraction in the same cycle; it takes priority over a fraction write and a tick in that cycle.
- R6: A tick at the maximum count wraps it to zero and sets the overflow flag (status bit 1); the count then stays frozen until that flag is cleared.
- R7: The alarm flag (status bit 0) sets one cycle after the seconds word becomes equal to the alarm value; an alarm value of all ones never sets it.
- R8: Writing a one in a bit of the clear mask clears that status flag (bit 0 alarm, bit 1 overflow); a zero leaves it, and a cleared alarm flag stays clear while the seconds word remains equal to the alarm.
- R9: The interrupt output is high exactly when the alarm flag and the alarm interrupt enable (control bit 1) are both set.
- R10: While control bit 0 is clear, seconds and fraction writes are ignored if the soft lock (control bit 2) or the hard lock (control bit 3) is set; with bit 0 set they are accepted.
- R11: The soft lock follows each control write; the hard lock, once written to one, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per 32.768 kHz period |
| invalid_i | input | 1 | Security controller reports stored time not valid |
| failure_i | input | 1 | Security controller reports failure state |
| sec_wr_i | input | 1 | Seconds write strobe |
| sec_wdata_i | input | 32 | Seconds write data |
| frac_wr_i | input | 1 | Fraction write strobe |
| frac_wdata_i | input | 15 | Fraction write data |
| alarm_wr_i | input | 1 | Alarm write strobe |
| alarm_wdata_i | input | 32 | Alarm seconds value |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 4 | Control data: bit0 enable, bit1 alarm irq enable, bit2 soft lock, bit3 hard lock |
| stat_clr_i | input | 1 | Status clear strobe |
| stat_clr_mask_i | input | 2 | Ones clear flags: bit0 alarm, bit1 overflow |
| sec_o | output | 32 | Current seconds word |
| frac_o | output | 15 | Current fraction |
| alarm_o | output | 32 | Alarm value |
| ctrl_o | output | 4 | Control register |
| status_o | output | 2 | bit0 alarm flag, bit1 overflow flag |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions assume the write strobes and the security inputs are synchronous to the block clock and hold for whole cycles, and that the tick strobe is at most one cycle wide per period in real use, though back-to-back ticks are legal and the count must follow them. The frozen-count property further assumes that nothing other than a tick or an accepted write moves the count, so the stimulus changes every input only at the falling clock edge and leaves the tick low while writes and mode changes settle. Overflow and alarm scenarios seed the count a few ticks below the boundary so each crossing happens within a handful of cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        ST_SEED = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } rtc_state_e;

    typedef struct packed {
        logic hard_lock;
        logic soft_lock;
        logic alarm_ie;
        logic enable;
    } rtc_ctrl_t;

    localparam int CTRL_W = 4;
    localparam int STAT_W = 2;
endpackage

// File: rtl/rtc_run_fsm.sv
module rtc_run_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic enable_i,
    input  logic ovf_i,
    input  logic invalid_i,
    input  logic failure_i,
    input  logic seed_wr_i,
    output logic count_en_o
);
    rtc_state_e state_q, state_d;
    logic       bad;

    assign bad = invalid_i | failure_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (bad) begin
            state_d = ST_SEED;
        end else begin
            unique case (state_q)
                ST_SEED: if (seed_wr_i)            state_d = ST_HOLD;
                ST_HOLD: if (enable_i && !ovf_i)   state_d = ST_RUN;
                ST_RUN:  if (!enable_i || ovf_i)   state_d = ST_HOLD;
                default:                           state_d = ST_SEED;
            endcase
        end
    end

    always_comb begin
        count_en_o = 1'b0;
        unique case (state_q)
            ST_RUN:  count_en_o = tick_i && enable_i && !ovf_i && !bad;
            default: count_en_o = 1'b0;
        endcase
    end

    // R3: a bad condition always forces the seed-wait state
    p_bad_seeds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (state_q == ST_SEED));
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en_i,
    input  logic              sec_ld_i,
    input  logic [SEC_W-1:0]  sec_val_i,
    input  logic              frac_ld_i,
    input  logic [FRAC_W-1:0] frac_val_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              wrap_o
);
    localparam int CNT_W = SEC_W + FRAC_W;

    logic [CNT_W-1:0] cnt_q;

    assign sec_o  = cnt_q[CNT_W-1:FRAC_W];
    assign frac_o = cnt_q[FRAC_W-1:0];
    assign wrap_o = count_en_i && !sec_ld_i && !frac_ld_i && (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (sec_ld_i)   cnt_q <= {sec_val_i, {FRAC_W{1'b0}}};
        else if (frac_ld_i)  cnt_q <= {cnt_q[CNT_W-1:FRAC_W], frac_val_i};
        else if (count_en_i) cnt_q <= cnt_q + 1'b1;
    end

    // R4: without a count enable or a write the count is frozen
    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en_i && !sec_ld_i && !frac_ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [SEC_W-1:0] alarm_i,
    input  logic             wrap_i,
    input  logic             clr_i,
    input  logic [1:0]       clr_mask_i,
    output logic             alarm_flag_o,
    output logic             ovf_flag_o
);
    logic match, match_q;

    assign match = (sec_i == alarm_i) && !(&alarm_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q      <= 1'b0;
            alarm_flag_o <= 1'b0;
            ovf_flag_o   <= 1'b0;
        end else begin
            match_q <= match;
            if (match && !match_q)              alarm_flag_o <= 1'b1;
            else if (clr_i && clr_mask_i[0])    alarm_flag_o <= 1'b0;
            if (wrap_i)                         ovf_flag_o   <= 1'b1;
            else if (clr_i && clr_mask_i[1])    ovf_flag_o   <= 1'b0;
        end
    end

    // R6: a wrap of the counter always leaves the overflow flag set
    p_wrap_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> ovf_flag_o);
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
    import rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              invalid_i,
    input  logic              failure_i,
    input  logic              sec_wr_i,
    input  logic [SEC_W-1:0]  sec_wdata_i,
    input  logic              frac_wr_i,
    input  logic [FRAC_W-1:0] frac_wdata_i,
    input  logic              alarm_wr_i,
    input  logic [SEC_W-1:0]  alarm_wdata_i,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              stat_clr_i,
    input  logic [STAT_W-1:0] stat_clr_mask_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [SEC_W-1:0]  alarm_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    rtc_ctrl_t        ctrl_q;
    rtc_ctrl_t        ctrl_w;
    logic [SEC_W-1:0] alarm_q;
    logic             blocked, sec_ld, frac_ld, count_en, wrap;
    logic             alarm_flag, ovf_flag;

    assign ctrl_w  = rtc_ctrl_t'(ctrl_wdata_i);
    assign blocked = !ctrl_q.enable && (ctrl_q.soft_lock || ctrl_q.hard_lock);
    assign sec_ld  = sec_wr_i && !blocked;
    assign frac_ld = frac_wr_i && !blocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            alarm_q <= '1;
        end else begin
            if (ctrl_wr_i) begin
                ctrl_q.enable    <= ctrl_w.enable;
                ctrl_q.alarm_ie  <= ctrl_w.alarm_ie;
                ctrl_q.soft_lock <= ctrl_w.soft_lock;
                ctrl_q.hard_lock <= ctrl_q.hard_lock | ctrl_w.hard_lock;
            end
            if (alarm_wr_i) alarm_q <= alarm_wdata_i;
        end
    end

    rtc_run_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .enable_i   (ctrl_q.enable),
        .ovf_i      (ovf_flag),
        .invalid_i  (invalid_i),
        .failure_i  (failure_i),
        .seed_wr_i  (sec_ld),
        .count_en_o (count_en)
    );

    rtc_time_cnt #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en_i (count_en),
        .sec_ld_i   (sec_ld),
        .sec_val_i  (sec_wdata_i),
        .frac_ld_i  (frac_ld),
        .frac_val_i (frac_wdata_i),
        .sec_o      (sec_o),
        .frac_o     (frac_o),
        .wrap_o     (wrap)
    );

    rtc_status_flags #(.SEC_W(SEC_W)) i_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_i        (sec_o),
        .alarm_i      (alarm_q),
        .wrap_i       (wrap),
        .clr_i        (stat_clr_i),
        .clr_mask_i   (stat_clr_mask_i),
        .alarm_flag_o (alarm_flag),
        .ovf_flag_o   (ovf_flag)
    );

    assign alarm_o  = alarm_q;
    assign ctrl_o   = ctrl_q;
    assign status_o = {ovf_flag, alarm_flag};
    assign irq_o    = alarm_flag && ctrl_q.alarm_ie;

    // R10: a locked, disabled counter ignores seconds writes
    p_locked_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_wr_i && !frac_wr_i && !ctrl_q.enable &&
         (ctrl_q.soft_lock || ctrl_q.hard_lock)) |=> $stable(sec_o));

    // R11: the hard lock never clears once set
    p_hard_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.hard_lock |=> ctrl_q.hard_lock);
endmodule

// File: tb/test_rtc_sec_alarm.sv
module test_rtc_sec_alarm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, invalid_i = 1'b0, failure_i = 1'b0;
    logic        sec_wr_i = 1'b0, frac_wr_i = 1'b0, alarm_wr_i = 1'b0;
    logic        ctrl_wr_i = 1'b0, stat_clr_i = 1'b0;
    logic [31:0] sec_wdata_i = '0, alarm_wdata_i = '0;
    logic [14:0] frac_wdata_i = '0;
    logic [3:0]  ctrl_wdata_i = '0;
    logic [1:0]  stat_clr_mask_i = '0;
    logic [31:0] sec_o, alarm_o;
    logic [14:0] frac_o;
    logic [3:0]  ctrl_o;
    logic [1:0]  status_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    rtc_sec_alarm i_rtc_sec_alarm (
        .clk, .rst_n, .tick_i, .invalid_i, .failure_i,
        .sec_wr_i, .sec_wdata_i, .frac_wr_i, .frac_wdata_i,
        .alarm_wr_i, .alarm_wdata_i, .ctrl_wr_i, .ctrl_wdata_i,
        .stat_clr_i, .stat_clr_mask_i,
        .sec_o, .frac_o, .alarm_o, .ctrl_o, .status_o, .irq_o
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic wr_sec(input logic [31:0] v);
        sec_wr_i = 1'b1; sec_wdata_i = v;
        @(negedge clk); sec_wr_i = 1'b0;
    endtask

    task automatic wr_frac(input logic [14:0] v);
        frac_wr_i = 1'b1; frac_wdata_i = v;
        @(negedge clk); frac_wr_i = 1'b0;
    endtask

    task automatic wr_alarm(input logic [31:0] v);
        alarm_wr_i = 1'b1; alarm_wdata_i = v;
        @(negedge clk); alarm_wr_i = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        ctrl_wr_i = 1'b1; ctrl_wdata_i = v;
        @(negedge clk); ctrl_wr_i = 1'b0;
    endtask

    task automatic clr_stat(input logic [1:0] m);
        stat_clr_i = 1'b1; stat_clr_mask_i = m;
        @(negedge clk); stat_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 sec", sec_o, 0);
        check("R1 frac", frac_o, 0);
        check("R1 alarm", alarm_o, 32'hFFFF_FFFF);
        check("R1 ctrl", ctrl_o, 0);
        check("R1 status", status_o, 0);
        ticks(3);
        check("R1 no count", frac_o, 0);
    endtask

    task automatic t_seed_and_count();
        wr_ctrl(4'b0001);
        ticks(5);
        check("R3 unseeded frozen", frac_o, 0);
        wr_sec(100);
        idle(2);
        ticks(5);
        check("R2 count sec", sec_o, 100);
        check("R2 count frac", frac_o, 5);
    endtask

    task automatic t_carry();
        wr_frac(15'd32766);
        ticks(3);
        check("R2 carry sec", sec_o, 101);
        check("R2 carry frac", frac_o, 1);
    endtask

    task automatic t_stop_causes();
        wr_ctrl(4'b0000);
        ticks(4);
        check("R4 disabled", frac_o, 1);
        wr_ctrl(4'b0001);
        idle(2);
        invalid_i = 1'b1; idle(1); invalid_i = 1'b0;
        idle(2);
        ticks(3);
        check("R3 after invalid", frac_o, 1);
        wr_sec(200);
        idle(2);
        ticks(2);
        check("R3 reseeded", frac_o, 2);
        failure_i = 1'b1;
        ticks(3);
        check("R4 failure held", frac_o, 2);
        failure_i = 1'b0;
        idle(2);
        ticks(2);
        check("R3 after failure", frac_o, 2);
    endtask

    task automatic t_write_priority();
        sec_wr_i = 1'b1; sec_wdata_i = 7;
        frac_wr_i = 1'b1; frac_wdata_i = 99;
        tick_i = 1'b1;
        @(negedge clk);
        sec_wr_i = 1'b0; frac_wr_i = 1'b0; tick_i = 1'b0;
        check("R5 sec loaded", sec_o, 7);
        check("R5 frac zeroed", frac_o, 0);
    endtask

    task automatic t_overflow();
        wr_sec(32'hFFFF_FFFF);
        wr_frac(15'd32765);
        idle(2);
        ticks(3);
        check("R6 wrap sec", sec_o, 0);
        check("R6 wrap frac", frac_o, 0);
        check("R6 ovf flag", status_o[1], 1);
        ticks(3);
        check("R6 frozen after wrap", frac_o, 0);
        clr_stat(2'b01);
        check("R8 mask keeps ovf", status_o[1], 1);
        clr_stat(2'b10);
        check("R8 ovf cleared", status_o[1], 0);
        idle(3);
        ticks(2);
        check("R6 resumes", frac_o, 2);
    endtask

    task automatic t_alarm();
        wr_alarm(50);
        wr_sec(49);
        wr_frac(15'd32766);
        idle(2);
        ticks(2);
        check("R7 reached", sec_o, 50);
        idle(2);
        check("R7 alarm flag", status_o[0], 1);
        check("R9 irq masked", irq_o, 0);
        wr_ctrl(4'b0011);
        check("R9 irq on", irq_o, 1);
        clr_stat(2'b01);
        check("R8 alarm cleared", status_o[0], 0);
        idle(3);
        check("R8 stays clear", status_o[0], 0);
        check("R9 irq off", irq_o, 0);
        wr_ctrl(4'b0001);
    endtask

    task automatic t_alarm_off();
        wr_alarm(32'hFFFF_FFFF);
        wr_sec(32'hFFFF_FFFF);
        idle(2);
        ticks(3);
        check("R7 disabled alarm", status_o[0], 0);
        check("R7 still counted", frac_o, 3);
    endtask

    task automatic t_locks();
        wr_ctrl(4'b0100);
        wr_sec(33);
        check("R10 soft blocks sec", sec_o, 32'hFFFF_FFFF);
        wr_frac(5);
        check("R10 soft blocks frac", frac_o, 3);
        wr_ctrl(4'b0000);
        check("R11 soft follows", ctrl_o[2], 0);
        wr_sec(33);
        check("R10 unlocked write", sec_o, 33);
        wr_ctrl(4'b1000);
        wr_ctrl(4'b0000);
        check("R11 hard sticky", ctrl_o[3], 1);
        wr_sec(44);
        check("R10 hard blocks", sec_o, 33);
        wr_ctrl(4'b1001);
        wr_sec(44);
        check("R10 enabled accepts", sec_o, 44);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seed_and_count();
        t_carry();
        t_stop_causes();
        t_write_priority();
        t_overflow();
        t_alarm();
        t_alarm_off();
        t_locks();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule